// File: doc/BRIEF.md
# 10G Receive Frame Aligner

This block is the first stage of a 10 Gb/s Ethernet receive path. Each clock it takes one 64-bit word from the media-independent interface, made of eight byte lanes with one control bit per lane. From that stream it recovers frames and emits them as 64-bit words. The first byte after the start-of-frame delimiter always sits in lane 0 of the first valid word. The preamble, the delimiter and the four-byte frame check sequence are removed on the fly.

The outputs are a valid strobe that covers the frame words and a per-lane byte enable for the short final word. There is also an error flag, raised on the final word when the CRC-32 fails or a control character shows up inside the frame. The next stage drops any frame that ends with this flag set. A frame may start in lane 0 or in lane 4. A frame that starts in lane 4 is shifted down by half a word through a held upper half. The block relies on a minimum inter-packet gap of four bytes so that the gaps between frames stay intact at the output.

Top module: `xgrx_frame_aligner`

## Requirements
- R1: A frame opens only when the start code 0xFB appears with its control bit set in lane 0 (bits 7:0) or lane 4 (bits 39:32). A start code in any other lane is ignored, and that frame produces no valid output word.
- R2: The first payload byte (the byte that follows the 0xD5 delimiter) appears in lane 0 of the first valid word, whichever of the two allowed lanes held the start code.
- R3: The output carries exactly the bytes between the delimiter and the terminate code 0xFD (control bit set), minus the last four of them, in arrival order, with lane 0 earliest.
- R4: The byte enables are 0xFF on every valid word except the last. The last word enables bits 0..k-1, where k is the payload length modulo 8 (eight when that is zero). Enable bit i belongs to lane i.
- R5: Data lanes whose enable is clear read as zero. While valid is low, data, enables and the error flag are all zero.
- R6: The error flag is raised when the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over the payload and the check sequence does not leave the fixed good-frame residue.
- R7: The error flag is raised when any frame byte before the terminate code, check-sequence bytes included, has its control bit set (for example the error code 0xFE).
- R8: The error flag can be high only on the last valid word of a frame, together with its final enables.
- R9: Valid is low for at least one cycle between two frames. This holds even when a terminate in lanes 0..3 and the next start in lane 4 share one input word.
- R10: A frame whose payload is empty (four or fewer bytes between delimiter and terminate) produces no valid word.
- R11: During and directly after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xgmii_d | input | 64 | Input data word, lane i in bits 8i+7:8i |
| xgmii_c | input | 8 | Per-lane control flags, bit i for lane i |
| rx_data | output | 64 | Aligned frame data, first byte in lane 0 |
| rx_valid | output | 1 | Word carries frame payload |
| rx_be | output | 8 | Byte enables, bit i for lane i |
| rx_err | output | 1 | Drop flag, on the last word only |

## Verification
The bench sweeps payload lengths across every terminate lane, for both start lanes. A fault in the half-word shift or in the FCS trimming would then show up as rotated data, a stray trailing byte or a wrong enable width. Frames with a runt payload, a start code in an unaccepted lane, and back-to-back frames that share one input word are all generated. A design that mishandled these would emit phantom words, merge two frames or lose the second one. Corrupted check sequences and control characters inside the payload, inside the check sequence and in the last payload byte are also sent. A design that checked the wrong byte range, or raised the flag on the wrong word, would leave a bad frame unflagged or flag a good one.

// File: rtl/xgrx_pkg.sv
`timescale 1ns/1ps
package xgrx_pkg;
  localparam int LANES     = 8;
  localparam int DW        = LANES * 8;
  localparam int HALF      = LANES / 2;
  localparam int CW        = $clog2(LANES + 1);
  localparam int FCS_BYTES = 4;

  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_IDLE  = 8'h07;

  // reflected form of 0x04C11DB7 and of the residue 0xC704DD7B
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_REFL = 32'hDEBB20E3;

  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    logic hit;
    cnt_t pos;
  } term_t;

  // lanes below n set
  function automatic logic [LANES-1:0] lead_mask(input cnt_t n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // lowest lane holding a terminate control code
  function automatic term_t first_term(input logic [DW-1:0] d, input logic [LANES-1:0] c);
    term_t r;
    r.hit = 1'b0;
    r.pos = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (c[i] && d[8*i +: 8] == CH_TERM) begin
        r.hit = 1'b1;
        r.pos = cnt_t'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] mask_bytes(input logic [DW-1:0] d, input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = m[i] ? d[8*i +: 8] : 8'h00;
    return r;
  endfunction

  // bitwise LSB-first CRC over the enabled lanes, lane 0 first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [DW-1:0] d,
                                           input logic [LANES-1:0] m, input logic [31:0] poly);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        for (int b = 0; b < 8; b++) begin
          fb = r[0] ^ d[8*i + b];
          r  = {1'b0, r[31:1]};
          if (fb) r = r ^ poly;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/xgrx_lane_align.sv
`timescale 1ns/1ps
module xgrx_lane_align
  import xgrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    in_d,
  input  logic [LANES-1:0] in_c,
  input  logic             shift_ld,
  input  logic             shift_new,
  output logic             start_lo,
  output logic             start_hi,
  output logic [DW-1:0]    al_d,
  output logic [LANES-1:0] al_c
);
  localparam int HB = HALF * 8;

  logic [DW-1:0]    r_d;
  logic [LANES-1:0] r_c;
  logic             shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_d     <= {LANES{CH_IDLE}};
      r_c     <= '1;
      shift_q <= 1'b0;
    end else begin
      r_d <= in_d;
      r_c <= in_c;
      if (shift_ld) shift_q <= shift_new;
    end
  end

  assign start_lo = r_c[0]    && (r_d[7:0]     == CH_START);
  assign start_hi = r_c[HALF] && (r_d[HB +: 8] == CH_START);

  always_comb begin
    if (shift_q) begin
      al_d = {in_d[HB-1:0], r_d[DW-1:HB]};
      al_c = {in_c[HALF-1:0], r_c[LANES-1:HALF]};
    end else begin
      al_d = r_d;
      al_c = r_c;
    end
  end
endmodule

// File: rtl/xgrx_crc_chk.sv
`timescale 1ns/1ps
module xgrx_crc_chk
  import xgrx_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY_REFL,
  parameter logic [31:0] GOOD = CRC_GOOD_REFL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic [DW-1:0]    d,
  input  logic [LANES-1:0] m,
  output logic             crc_ok
);
  logic [31:0] crc_q;
  logic [31:0] crc_n;

  assign crc_n  = crc_step(crc_q, d, m, POLY);
  assign crc_ok = (crc_n == GOOD);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (upd)  crc_q <= crc_n;
  end
endmodule

// File: rtl/xgrx_fcs_strip.sv
`timescale 1ns/1ps
module xgrx_fcs_strip
  import xgrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             body_word,
  input  logic             term_hit,
  input  cnt_t             term_pos,
  input  logic [DW-1:0]    al_d,
  input  logic             frame_bad,
  output logic             o_valid,
  output logic [DW-1:0]    o_data,
  output logic [LANES-1:0] o_be,
  output logic             o_err
);
  localparam cnt_t FCS_C  = cnt_t'(FCS_BYTES);
  localparam cnt_t KEEP_C = cnt_t'(LANES - FCS_BYTES);

  logic             hold_v, hold_v_n;
  logic [DW-1:0]    hold_d, hold_d_n;
  logic             tail_v, tail_v_n;
  logic [DW-1:0]    tail_d, tail_d_n;
  logic [LANES-1:0] tail_b, tail_b_n;
  logic             tail_e, tail_e_n;
  logic             nv, ne;
  logic [DW-1:0]    nd;
  logic [LANES-1:0] nb;

  always_comb begin
    nv = 1'b0; nd = '0; nb = '0; ne = 1'b0;
    hold_v_n = hold_v; hold_d_n = hold_d;
    tail_v_n = 1'b0;   tail_d_n = tail_d; tail_b_n = tail_b; tail_e_n = tail_e;
    if (tail_v) begin
      nv = 1'b1; nd = tail_d; nb = tail_b; ne = tail_e;
    end
    if (body_word) begin
      if (hold_v) begin
        nv = 1'b1; nd = hold_d; nb = '1; ne = 1'b0;
      end
      hold_d_n = al_d;
      hold_v_n = 1'b1;
    end else if (term_hit) begin
      hold_v_n = 1'b0;
      if (term_pos >= FCS_C) begin
        if (hold_v) begin
          nv = 1'b1; nd = hold_d; nb = '1;
          ne = frame_bad && (term_pos == FCS_C);
        end
        if (term_pos > FCS_C) begin
          tail_v_n = 1'b1;
          tail_b_n = lead_mask(term_pos - FCS_C);
          tail_d_n = mask_bytes(al_d, tail_b_n);
          tail_e_n = frame_bad;
        end
      end else if (hold_v) begin
        nv = 1'b1;
        nb = lead_mask(term_pos + KEEP_C);
        nd = mask_bytes(hold_d, nb);
        ne = frame_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_d <= '0;
      tail_v <= 1'b0; tail_d <= '0; tail_b <= '0; tail_e <= 1'b0;
      o_valid <= 1'b0; o_data <= '0; o_be <= '0; o_err <= 1'b0;
    end else begin
      hold_v <= hold_v_n; hold_d <= hold_d_n;
      tail_v <= tail_v_n; tail_d <= tail_d_n; tail_b <= tail_b_n; tail_e <= tail_e_n;
      o_valid <= nv; o_data <= nd; o_be <= nb; o_err <= ne;
    end
  end
endmodule

// File: rtl/xgrx_frame_aligner.sv
`timescale 1ns/1ps
module xgrx_frame_aligner
  import xgrx_pkg::*;
#(
  parameter logic [31:0] CRC_POLY = CRC_POLY_REFL,
  parameter logic [31:0] CRC_GOOD = CRC_GOOD_REFL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    xgmii_d,
  input  logic [LANES-1:0] xgmii_c,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic [LANES-1:0] rx_be,
  output logic             rx_err
);
  logic             start_lo, start_hi;
  logic [DW-1:0]    al_d;
  logic [LANES-1:0] al_c;
  logic             in_body;
  logic             err_acc;
  term_t            term;
  logic             term_hit, start_ok, body_word, word_err, crc_ok, frame_bad;
  cnt_t             nbytes;
  logic [LANES-1:0] body_mask;

  xgrx_lane_align u_align (
    .clk(clk), .rst_n(rst_n), .in_d(xgmii_d), .in_c(xgmii_c),
    .shift_ld(start_ok), .shift_new(start_hi && !start_lo),
    .start_lo(start_lo), .start_hi(start_hi), .al_d(al_d), .al_c(al_c)
  );

  assign term      = first_term(al_d, al_c);
  assign term_hit  = in_body && term.hit;
  assign body_word = in_body && !term.hit;
  assign start_ok  = (start_lo || start_hi) && (!in_body || term_hit);
  assign nbytes    = term.hit ? term.pos : cnt_t'(LANES);
  assign body_mask = lead_mask(nbytes);
  assign word_err  = |(al_c & body_mask);

  xgrx_crc_chk #(.POLY(CRC_POLY), .GOOD(CRC_GOOD)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(start_ok), .upd(body_word),
    .d(al_d), .m(body_mask), .crc_ok(crc_ok)
  );

  assign frame_bad = err_acc || word_err || !crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_body <= 1'b0;
      err_acc <= 1'b0;
    end else begin
      if (start_ok)      in_body <= 1'b1;
      else if (term_hit) in_body <= 1'b0;
      if (start_ok)       err_acc <= 1'b0;
      else if (body_word) err_acc <= err_acc || word_err;
    end
  end

  xgrx_fcs_strip u_strip (
    .clk(clk), .rst_n(rst_n), .body_word(body_word), .term_hit(term_hit),
    .term_pos(term.pos), .al_d(al_d), .frame_bad(frame_bad),
    .o_valid(rx_valid), .o_data(rx_data), .o_be(rx_be), .o_err(rx_err)
  );
endmodule

// File: rtl/xgrx_frame_aligner_chk.sv
`timescale 1ns/1ps
module xgrx_frame_aligner_chk
  import xgrx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [DW-1:0]    rx_data,
  input logic [LANES-1:0] rx_be,
  input logic             rx_err,
  input logic             start_ok
);
  // R4: enables form a non-empty run from lane 0
  a_r4_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_be != '0) && (((rx_be + 1'b1) & rx_be) == '0));

  // R4: a partial word closes the frame
  a_r4_partial_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (rx_be != '1) |=> !rx_valid);

  // R8: the drop flag rides only on the closing word
  a_r8_err_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_err |=> !rx_valid);

  // R5: quiet outputs between words
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_be == '0) && (rx_data == '0) && !rx_err);

  // R9: an accepted start is followed by a cycle without a word
  a_r9_gap_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> ##1 !rx_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // R5: disabled lanes carry zero
    a_r5_dead_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_be[i] |-> rx_data[8*i +: 8] == 8'h00);
  end
endmodule

bind xgrx_frame_aligner xgrx_frame_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_be(rx_be), .rx_err(rx_err), .start_ok(start_ok)
);

// File: tb/tb_xgrx_frame_aligner.sv
`timescale 1ns/1ps
module tb_xgrx_frame_aligner;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] xd;
  logic [7:0]  xc;
  logic [63:0] rx_data;
  logic        rx_valid;
  logic [7:0]  rx_be;
  logic        rx_err;

  always #4 clk = ~clk;

  xgrx_frame_aligner dut (
    .clk(clk), .rst_n(rst_n), .xgmii_d(xd), .xgmii_c(xc),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_be(rx_be), .rx_err(rx_err)
  );

  byte unsigned sb[$];
  bit           sc[$];
  logic [63:0]  ed[$];
  logic [7:0]   eb[$];
  bit           ee[$];
  bit           el[$];
  int checks = 0, fails = 0, fno = 0;
  bit done = 1'b0;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input byte unsigned b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input byte unsigned b, input bit c);
    sb.push_back(b);
    sc.push_back(c);
  endtask

  // start lane slane, payload plen, error char at frame index err_at (-1: none)
  task automatic add_frame(input int plen, input int slane, input bit bad_fcs,
                           input int err_at, input bit expect_out);
    byte unsigned fb[$];
    logic [31:0]  crc;
    int           nw;
    while ((sb.size() % 8) != slane) push(8'h07, 1'b1);
    push(8'hFB, 1'b1);
    repeat (6) push(8'h55, 1'b0);
    push(8'hD5, 1'b0);
    crc = '1;
    for (int i = 0; i < plen; i++) begin
      byte unsigned b;
      b = byte'((i * 37 + fno * 11 + 5) & 255);
      fb.push_back(b);
      crc = crc_byte(crc, b);
    end
    crc = ~crc;
    for (int k = 0; k < 4; k++) fb.push_back(crc[8*k +: 8]);
    if (bad_fcs) fb[plen] = fb[plen] ^ 8'h01;
    for (int i = 0; i < fb.size(); i++) begin
      if (i == err_at) fb[i] = 8'hFE;
      push(fb[i], i == err_at);
    end
    push(8'hFD, 1'b1);
    repeat (3) push(8'h07, 1'b1);
    if (expect_out && plen > 0) begin
      nw = (plen + 7) / 8;
      for (int w = 0; w < nw; w++) begin
        logic [63:0] d;
        logic [7:0]  be;
        d = '0; be = '0;
        for (int l = 0; l < 8; l++) begin
          if (w * 8 + l < plen) begin
            d[8*l +: 8] = fb[w * 8 + l];
            be[l] = 1'b1;
          end
        end
        ed.push_back(d);
        eb.push_back(be);
        el.push_back(w == nw - 1);
        ee.push_back((w == nw - 1) && (bad_fcs || err_at >= 0));
      end
    end
    fno++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit prev_last;
    int nwords;
    rst_n = 1'b0;
    xd = {8{8'h07}};
    xc = 8'hFF;
    prev_last = 1'b0;

    // R10: runt with empty payload
    add_frame(0, 0, 0, -1, 1);
    add_frame(0, 4, 0, -1, 1);
    // R2 R3 R4: every terminate lane from both start lanes
    for (int p = 1; p <= 17; p++) add_frame(p, 0, 0, -1, 1);
    for (int p = 1; p <= 17; p++) add_frame(p, 4, 0, -1, 1);
    add_frame(64, 0, 0, -1, 1);
    add_frame(64, 4, 0, -1, 1);
    // R9: terminate and next start share a word, and tight lane 4 to lane 0
    add_frame(12, 0, 0, -1, 1);
    add_frame(20, 4, 0, -1, 1);
    add_frame(16, 4, 0, -1, 1);
    add_frame(12, 4, 0, -1, 1);
    add_frame(9, 0, 0, -1, 1);
    add_frame(60, 0, 0, -1, 1);
    add_frame(33, 4, 0, -1, 1);
    // R6: corrupted check sequence
    add_frame(20, 0, 1, -1, 1);
    add_frame(21, 4, 1, -1, 1);
    add_frame(3, 0, 1, -1, 1);
    // R7: control characters in payload, in check sequence, in last byte
    add_frame(30, 0, 0, 5, 1);
    add_frame(30, 4, 0, 31, 1);
    add_frame(13, 4, 0, 12, 1);
    add_frame(8, 0, 0, 11, 1);
    // R1: starts in unaccepted lanes, then a normal frame
    add_frame(30, 2, 0, -1, 0);
    add_frame(25, 6, 0, -1, 0);
    add_frame(10, 0, 0, -1, 1);
    repeat (16) push(8'h07, 1'b1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rx_valid && rx_be == 8'h00 && rx_data == 64'h0 && !rx_err, "R11 reset outputs",
        {rx_data[55:0], rx_be}, 64'h0);
    rst_n = 1'b1;

    nwords = (sb.size() + 7) / 8 + 12;
    for (int cyc = 0; cyc < nwords; cyc++) begin
      @(negedge clk);
      if (prev_last) chk(!rx_valid, "R9 gap after last word", {63'h0, rx_valid}, 64'h0);
      prev_last = 1'b0;
      if (rx_valid) begin
        if (ed.size() == 0) begin
          chk(1'b0, "R1 R10 unexpected word", rx_data, 64'h0);
        end else begin
          logic [63:0] d;
          logic [7:0]  b;
          bit          e;
          d = ed.pop_front(); b = eb.pop_front(); e = ee.pop_front();
          prev_last = el.pop_front();
          chk(rx_data == d, "R2 R3 R5 data", rx_data, d);
          chk(rx_be == b, "R4 byte enables", {56'h0, rx_be}, {56'h0, b});
          chk(rx_err == e, "R6 R7 R8 error flag", {63'h0, rx_err}, {63'h0, e});
        end
      end
      for (int l = 0; l < 8; l++) begin
        int idx;
        idx = cyc * 8 + l;
        if (idx < sb.size()) begin
          xd[8*l +: 8] = sb[idx];
          xc[l] = sc[idx];
        end else begin
          xd[8*l +: 8] = 8'h07;
          xc[l] = 1'b1;
        end
      end
    end
    chk(ed.size() == 0, "R3 words missing", ed.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule